// File: doc/BRIEF.md
# Command Frame Parser and Dispatcher

This block sits behind an Ethernet controller that hands over each received frame as a byte stream. The stream begins at the destination MAC address, because the preamble has already been removed, and it marks the first and the last byte of each frame. The block compares all six destination bytes with a local MAC address supplied on an input, so it does not depend on the controller's own address check. It skips the rest of the 14-byte MAC header and reads the payload. The first payload byte identifies the slot the command is addressed to. The second payload byte is a one-byte command code.

Four command codes are recognised: hard reset, soft reset, status query and DAC programming. The soft-reset code is the hard-reset code with its top bit set. A soft-reset frame also carries the partner's MAC address, a debug byte and a reset-mask byte. When a frame is complete and valid, the block raises one single-cycle trigger for its command. It also updates the slot byte it holds and, for a soft reset, the partner address, the debug byte and the mask. Other logic receives the triggers: a reset sequencer, a query engine, and a programming handler that reads the rest of a programming frame on its own.

Top module: `cmd_frame_parser`

## Requirements
- R1: While rst_n is low, and after it is released with no frame received, every pulse output is 0 and cmd_location, partner_mac, soft_debug and soft_mask are all 0.
- R2: Frame bytes 0..5 must equal local_mac, with byte 0 compared to local_mac[47:40] and byte 5 to local_mac[7:0]. If any one of the six bytes differs, the frame raises no pulse and leaves every held output unchanged.
- R3: Frame byte 15 holds the command code. Code 0x52 raises hard_pulse. A frame of at least 16 bytes is enough for it.
- R4: Code 0x51 raises query_pulse. A frame of at least 16 bytes is enough for it.
- R5: Code 0x50 raises prog_pulse. A frame of at least 16 bytes is enough for it, and any bytes after byte 15 do not affect it.
- R6: Code 0xD2 needs a frame of at least 24 bytes and raises soft_pulse. In the same cycle, partner_mac takes frame bytes 16..21 (byte 16 into bits 47:40), soft_debug takes byte 22 and soft_mask takes byte 23.
- R7: spi_rst_pulse equals soft_pulse AND mask bit 1. dac_rst_pulse equals soft_pulse AND mask bit 0. Neither pulse is raised for any other command.
- R8: Any other code in byte 15 raises no pulse and leaves all held outputs unchanged. On every accepted command, cmd_location takes frame byte 14.
- R9: A frame that ends before the bytes its command needs (16, or 24 for a soft reset) raises no pulse and leaves all held outputs unchanged.
- R10: Each pulse lasts one cycle. At most one command pulse is high at a time. The pulse is high in the second cycle after the clock edge that accepts the end-of-frame byte.
- R11: A byte is taken only when rx_valid is high. Idle cycles inside a frame are skipped. Bytes received outside a frame are ignored. A start marker arriving in the middle of a frame drops the partial frame and starts a new one.
- R12: Bytes after the last field a command needs (padding) are ignored. A new frame may start in the cycle right after the end-of-frame byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| local_mac | input | 48 | Board's own MAC address; bits 47:40 are sent first |
| rx_valid | input | 1 | A frame byte is present on rx_data |
| rx_sof | input | 1 | This byte is the first byte of a frame |
| rx_eof | input | 1 | This byte is the last byte of a frame |
| rx_data | input | 8 | Frame byte |
| hard_pulse | output | 1 | Hard-reset trigger |
| soft_pulse | output | 1 | Soft-reset trigger |
| query_pulse | output | 1 | Status-query trigger |
| prog_pulse | output | 1 | DAC-programming trigger |
| spi_rst_pulse | output | 1 | Soft reset with the SPI-bus flag set |
| dac_rst_pulse | output | 1 | Soft reset with the DAC flag set |
| cmd_location | output | 8 | Slot byte of the last accepted command |
| partner_mac | output | 48 | Partner MAC address from the last soft reset |
| soft_debug | output | 8 | Debug byte from the last soft reset |
| soft_mask | output | 8 | Reset mask from the last soft reset |

## Verification
The hardest cases to reach are frames that look almost valid. One is a destination address that differs from the local address only in its last byte. Another is a soft-reset frame cut off at its 23rd byte, one byte before the mask. A third is a partial frame abandoned by a new start marker after its partner-address bytes have already been captured. The stimulus builds each of these frames byte by byte. After each one it sends an accepted command, so that the held outputs that a wrong commit would have changed are compared against a bench model. Back-to-back frames, idle cycles inside a frame and stray bytes between frames are mixed in, so that the position counter is tested across frame boundaries.

// File: rtl/cmdp_pkg.sv
// Package: shared constants and types for the command frame parser.
// Assumes frames are delivered starting at the destination MAC address.
package cmdp_pkg;
    localparam int MAC_BYTES = 6;
    localparam int HDR_BYTES = 2 * MAC_BYTES + 2;   // dest, source, length
    localparam int POS_LOC   = HDR_BYTES;           // slot byte
    localparam int POS_TYPE  = HDR_BYTES + 1;       // command code
    localparam int POS_PMAC  = HDR_BYTES + 2;       // first partner MAC byte
    localparam int POS_DBG   = POS_PMAC + MAC_BYTES;
    localparam int POS_MASK  = POS_DBG + 1;
    localparam int POS_LIMIT = POS_MASK + 1;        // saturation point
    localparam int POS_W     = $clog2(POS_LIMIT + 1);
    localparam int MASK_SPI  = 1;
    localparam int MASK_DAC  = 0;

    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic [7:0] {
        CODE_PROG  = 8'h50,
        CODE_QUERY = 8'h51,
        CODE_HARD  = 8'h52,
        CODE_SOFT  = 8'hD2
    } cmd_code_e;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_HARD,
        KIND_SOFT,
        KIND_QUERY,
        KIND_PROG
    } cmd_kind_e;
endpackage

// File: rtl/cmdp_byte_pos.sv
// Module: tracks the position of the current byte within a frame.
// Assumes rx_sof and rx_eof are only meaningful while rx_valid is high.
// Positions saturate at POS_LIMIT; bytes beyond it are treated as padding.
module cmdp_byte_pos
    import cmdp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic rx_sof,
    input  logic rx_eof,
    output logic byte_live,
    output pos_t pos
);
    localparam pos_t POS_SAT = pos_t'(POS_LIMIT);

    logic in_frame_q;
    pos_t next_q;

    assign byte_live = rx_valid && (rx_sof || in_frame_q);
    assign pos       = rx_sof ? '0 : next_q;

    // Advance the position and the in-frame flag on each byte taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            next_q     <= '0;
        end else if (byte_live) begin
            in_frame_q <= !rx_eof;
            next_q     <= (pos == POS_SAT) ? POS_SAT : pos + 1'b1;
        end
    end
endmodule

// File: rtl/cmdp_mac_filter.sv
// Module: compares all six destination bytes with the local MAC address.
// Assumes the first frame byte corresponds to local_mac's top byte.
// mac_ok is registered and is valid once the address bytes have passed.
module cmdp_mac_filter
    import cmdp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [8*MAC_BYTES-1:0] local_mac,
    input  logic                   byte_live,
    input  pos_t                   pos,
    input  logic [7:0]             rx_data,
    output logic                   mac_ok
);
    logic [7:0] want [MAC_BYTES];
    logic [7:0] want_now;
    logic       in_addr;
    logic       miss_q;

    for (genvar g = 0; g < MAC_BYTES; g++) begin : g_want
        assign want[g] = local_mac[8*(MAC_BYTES-1-g) +: 8];
    end

    assign in_addr = pos < pos_t'(MAC_BYTES);

    // Select the expected address byte for the current position.
    always_comb begin
        want_now = '0;
        for (int i = 0; i < MAC_BYTES; i++) begin
            if (pos == pos_t'(i)) want_now = want[i];
        end
    end

    // Accumulate a mismatch over the address bytes, restarting at byte 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_q <= 1'b0;
        end else if (byte_live && in_addr) begin
            miss_q <= (rx_data != want_now) || (miss_q && (pos != '0));
        end
    end

    assign mac_ok = !miss_q;
endmodule

// File: rtl/cmdp_field_capture.sv
// Module: shadow registers for the payload fields of the current frame.
// Assumes fields are committed elsewhere only after a complete frame;
// stale values are harmless since the length check covers every field.
module cmdp_field_capture
    import cmdp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   byte_live,
    input  pos_t                   pos,
    input  logic [7:0]             rx_data,
    output logic [7:0]             sh_loc,
    output logic [7:0]             sh_type,
    output logic [8*MAC_BYTES-1:0] sh_pmac,
    output logic [7:0]             sh_dbg,
    output logic [7:0]             sh_mask
);
    // Capture the slot, code, debug and mask bytes at their positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_loc  <= '0;
            sh_type <= '0;
            sh_dbg  <= '0;
            sh_mask <= '0;
        end else if (byte_live) begin
            if (pos == pos_t'(POS_LOC))  sh_loc  <= rx_data;
            if (pos == pos_t'(POS_TYPE)) sh_type <= rx_data;
            if (pos == pos_t'(POS_DBG))  sh_dbg  <= rx_data;
            if (pos == pos_t'(POS_MASK)) sh_mask <= rx_data;
        end
    end

    for (genvar g = 0; g < MAC_BYTES; g++) begin : g_pmac
        logic [7:0] b_q;
        // Capture partner MAC byte g, first byte into the top slice.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                b_q <= '0;
            end else if (byte_live && (pos == pos_t'(POS_PMAC + g))) begin
                b_q <= rx_data;
            end
        end
        assign sh_pmac[8*(MAC_BYTES-1-g) +: 8] = b_q;
    end
endmodule

// File: rtl/cmdp_dispatch.sv
// Module: decodes the command code after end-of-frame, checks length and
// address, commits held fields and issues single-cycle triggers.
// Assumes shadow fields settle at the edge that takes the last byte.
module cmdp_dispatch
    import cmdp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   byte_live,
    input  logic                   rx_eof,
    input  pos_t                   pos,
    input  logic                   mac_ok,
    input  logic [7:0]             sh_loc,
    input  logic [7:0]             sh_type,
    input  logic [8*MAC_BYTES-1:0] sh_pmac,
    input  logic [7:0]             sh_dbg,
    input  logic [7:0]             sh_mask,
    output logic                   hard_pulse,
    output logic                   soft_pulse,
    output logic                   query_pulse,
    output logic                   prog_pulse,
    output logic                   spi_rst_pulse,
    output logic                   dac_rst_pulse,
    output logic [7:0]             cmd_location,
    output logic [8*MAC_BYTES-1:0] partner_mac,
    output logic [7:0]             soft_debug,
    output logic [7:0]             soft_mask
);
    logic      done_q;
    pos_t      last_q;
    cmd_kind_e kind;
    logic      long_ok;
    logic      fire;

    // Remember that a frame ended and the position of its last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            last_q <= '0;
        end else begin
            done_q <= byte_live && rx_eof;
            if (byte_live && rx_eof) last_q <= pos;
        end
    end

    // Map the captured code onto a command kind.
    always_comb begin
        case (sh_type)
            CODE_HARD:  kind = KIND_HARD;
            CODE_SOFT:  kind = KIND_SOFT;
            CODE_QUERY: kind = KIND_QUERY;
            CODE_PROG:  kind = KIND_PROG;
            default:    kind = KIND_NONE;
        endcase
    end

    assign long_ok = (kind == KIND_SOFT) ? (last_q >= pos_t'(POS_MASK))
                                         : (last_q >= pos_t'(POS_TYPE));
    assign fire    = done_q && mac_ok && long_ok && (kind != KIND_NONE);

    // Issue triggers and commit the held fields of an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hard_pulse    <= 1'b0;
            soft_pulse    <= 1'b0;
            query_pulse   <= 1'b0;
            prog_pulse    <= 1'b0;
            spi_rst_pulse <= 1'b0;
            dac_rst_pulse <= 1'b0;
            cmd_location  <= '0;
            partner_mac   <= '0;
            soft_debug    <= '0;
            soft_mask     <= '0;
        end else begin
            hard_pulse    <= fire && (kind == KIND_HARD);
            soft_pulse    <= fire && (kind == KIND_SOFT);
            query_pulse   <= fire && (kind == KIND_QUERY);
            prog_pulse    <= fire && (kind == KIND_PROG);
            spi_rst_pulse <= fire && (kind == KIND_SOFT) && sh_mask[MASK_SPI];
            dac_rst_pulse <= fire && (kind == KIND_SOFT) && sh_mask[MASK_DAC];
            if (fire) cmd_location <= sh_loc;
            if (fire && (kind == KIND_SOFT)) begin
                partner_mac <= sh_pmac;
                soft_debug  <= sh_dbg;
                soft_mask   <= sh_mask;
            end
        end
    end
endmodule

// File: rtl/cmd_frame_parser.sv
// Module: top level of the command frame parser and dispatcher.
// Assumes a byte stream starting at the destination MAC, with start and
// end markers qualified by rx_valid; CRC is checked upstream.
module cmd_frame_parser
    import cmdp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [47:0] local_mac,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [7:0]  rx_data,
    output logic        hard_pulse,
    output logic        soft_pulse,
    output logic        query_pulse,
    output logic        prog_pulse,
    output logic        spi_rst_pulse,
    output logic        dac_rst_pulse,
    output logic [7:0]  cmd_location,
    output logic [47:0] partner_mac,
    output logic [7:0]  soft_debug,
    output logic [7:0]  soft_mask
);
    logic       byte_live;
    pos_t       pos;
    logic       mac_ok;
    logic [7:0] sh_loc, sh_type, sh_dbg, sh_mask;
    logic [47:0] sh_pmac;

    cmdp_byte_pos i_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_sof    (rx_sof),
        .rx_eof    (rx_eof),
        .byte_live (byte_live),
        .pos       (pos)
    );

    cmdp_mac_filter i_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .local_mac (local_mac),
        .byte_live (byte_live),
        .pos       (pos),
        .rx_data   (rx_data),
        .mac_ok    (mac_ok)
    );

    cmdp_field_capture i_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_live (byte_live),
        .pos       (pos),
        .rx_data   (rx_data),
        .sh_loc    (sh_loc),
        .sh_type   (sh_type),
        .sh_pmac   (sh_pmac),
        .sh_dbg    (sh_dbg),
        .sh_mask   (sh_mask)
    );

    cmdp_dispatch i_disp (
        .clk           (clk),
        .rst_n         (rst_n),
        .byte_live     (byte_live),
        .rx_eof        (rx_eof),
        .pos           (pos),
        .mac_ok        (mac_ok),
        .sh_loc        (sh_loc),
        .sh_type       (sh_type),
        .sh_pmac       (sh_pmac),
        .sh_dbg        (sh_dbg),
        .sh_mask       (sh_mask),
        .hard_pulse    (hard_pulse),
        .soft_pulse    (soft_pulse),
        .query_pulse   (query_pulse),
        .prog_pulse    (prog_pulse),
        .spi_rst_pulse (spi_rst_pulse),
        .dac_rst_pulse (dac_rst_pulse),
        .cmd_location  (cmd_location),
        .partner_mac   (partner_mac),
        .soft_debug    (soft_debug),
        .soft_mask     (soft_mask)
    );
endmodule

// File: rtl/cmdp_checker.sv
// Module: assertion checker bound to cmd_frame_parser.
// Assumes the reset is synchronous and active low.
module cmdp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_valid,
    input logic        rx_eof,
    input logic        hard_pulse,
    input logic        soft_pulse,
    input logic        query_pulse,
    input logic        prog_pulse,
    input logic        spi_rst_pulse,
    input logic        dac_rst_pulse,
    input logic [7:0]  cmd_location,
    input logic [47:0] partner_mac,
    input logic [7:0]  soft_debug,
    input logic [7:0]  soft_mask
);
    logic any_cmd;
    assign any_cmd = hard_pulse || soft_pulse || query_pulse || prog_pulse;

    p_one_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hard_pulse, soft_pulse, query_pulse, prog_pulse}));

    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        any_cmd |=> !any_cmd);

    p_after_eof_r10: assert property (@(posedge clk) disable iff (!rst_n)
        any_cmd |-> $past(rx_valid && rx_eof, 2));

    p_spi_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_rst_pulse |-> (soft_pulse && soft_mask[1]));

    p_dac_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dac_rst_pulse |-> (soft_pulse && soft_mask[0]));

    p_soft_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({partner_mac, soft_debug, soft_mask}) |-> soft_pulse);

    p_loc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_location) |-> any_cmd);
endmodule

bind cmd_frame_parser cmdp_checker i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_eof        (rx_eof),
    .hard_pulse    (hard_pulse),
    .soft_pulse    (soft_pulse),
    .query_pulse   (query_pulse),
    .prog_pulse    (prog_pulse),
    .spi_rst_pulse (spi_rst_pulse),
    .dac_rst_pulse (dac_rst_pulse),
    .cmd_location  (cmd_location),
    .partner_mac   (partner_mac),
    .soft_debug    (soft_debug),
    .soft_mask     (soft_mask)
);

// File: tb/test_cmd_frame_parser.sv
// Bench: scoreboard for cmd_frame_parser. The driver pushes expected
// commands; a monitor pops them when pulses appear and compares.
module test_cmd_frame_parser;
    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] OWN_MAC = 48'h02_A1_B2_C3_D4_05;
    localparam int K_NONE = 0, K_HARD = 1, K_SOFT = 2, K_QUERY = 3, K_PROG = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0] rx_data = '0;
    logic hard_pulse, soft_pulse, query_pulse, prog_pulse;
    logic spi_rst_pulse, dac_rst_pulse;
    logic [7:0] cmd_location, soft_debug, soft_mask;
    logic [47:0] partner_mac;

    typedef struct {
        int          kind;
        int          cyc;
        string       req;
        logic [7:0]  loc;
        logic [47:0] pmac;
        logic [7:0]  dbg;
        logic [7:0]  mask;
    } exp_t;

    exp_t        sb[$];
    logic [7:0]  fb[$];
    int          total = 0, bad = 0, cyc = 0;
    logic [7:0]  m_loc = '0, m_dbg = '0, m_mask = '0;
    logic [47:0] m_pmac = '0;

    cmd_frame_parser i_cmd_frame_parser (
        .clk(clk), .rst_n(rst_n), .local_mac(OWN_MAC),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .hard_pulse(hard_pulse), .soft_pulse(soft_pulse),
        .query_pulse(query_pulse), .prog_pulse(prog_pulse),
        .spi_rst_pulse(spi_rst_pulse), .dac_rst_pulse(dac_rst_pulse),
        .cmd_location(cmd_location), .partner_mac(partner_mac),
        .soft_debug(soft_debug), .soft_mask(soft_mask)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] kind_vec(input int k);
        case (k)
            K_HARD:  return 4'b1000;
            K_SOFT:  return 4'b0100;
            K_QUERY: return 4'b0010;
            K_PROG:  return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

    // Build header, slot byte and command code for one frame.
    task automatic frame_base(input logic [47:0] dst, input logic [7:0] loc,
                              input logic [7:0] code);
        fb.delete();
        for (int i = 5; i >= 0; i--) fb.push_back(dst[8*i +: 8]);
        for (int i = 0; i < 6; i++) fb.push_back(8'hA0 + 8'(i));
        fb.push_back(8'h00);
        fb.push_back(8'h2E);
        fb.push_back(loc);
        fb.push_back(code);
    endtask

    task automatic pad_to(input int n);
        while (fb.size() < n) fb.push_back(8'hEE);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        end
    endtask

    // Drive fb; on the last byte update the model and push the expectation.
    task automatic send(input int kind, input string req, input int gap_at,
                        input bit with_eof);
        exp_t e;
        for (int i = 0; i < fb.size(); i++) begin
            if (i == gap_at) idle(2);
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = with_eof && (i == fb.size() - 1);
            rx_data  = fb[i];
            if (rx_eof && kind != K_NONE) begin
                m_loc = fb[14];
                if (kind == K_SOFT) begin
                    m_pmac = {fb[16], fb[17], fb[18], fb[19], fb[20], fb[21]};
                    m_dbg  = fb[22];
                    m_mask = fb[23];
                end
                e.kind = kind; e.cyc = cyc + 2; e.req = req;
                e.loc = m_loc; e.pmac = m_pmac; e.dbg = m_dbg; e.mask = m_mask;
                sb.push_back(e);
            end
        end
    endtask

    // Held outputs must still match the model after a dropped frame.
    task automatic hold_check(input string req);
        idle(4);
        check(req, "pulses idle", {hard_pulse, soft_pulse, query_pulse, prog_pulse}, 0);
        check(req, "location held", cmd_location, m_loc);
        check(req, "partner held", partner_mac, m_pmac);
        check(req, "debug/mask held", {soft_debug, soft_mask}, {m_dbg, m_mask});
    endtask

    // Monitor: pop an expectation for each pulse and compare.
    logic [3:0] prev_p = '0;
    always @(negedge clk) begin
        logic [3:0] p;
        exp_t e;
        p = {hard_pulse, soft_pulse, query_pulse, prog_pulse};
        if (rst_n && p != 0) begin
            check("R10", "pulse width", prev_p, 0);
            if (sb.size() == 0) begin
                check("R8", "unexpected pulse", p, 0);
            end else begin
                e = sb.pop_front();
                check(e.req, "kind", p, kind_vec(e.kind));
                check("R10", "pulse cycle", cyc, e.cyc);
                check(e.req, "location", cmd_location, e.loc);
                check(e.req, "partner mac", partner_mac, e.pmac);
                check(e.req, "debug", soft_debug, e.dbg);
                check(e.req, "mask", soft_mask, e.mask);
                check("R7", "spi flag", spi_rst_pulse, (e.kind == K_SOFT) && e.mask[1]);
                check("R7", "dac flag", dac_rst_pulse, (e.kind == K_SOFT) && e.mask[0]);
            end
        end
        prev_p = p;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "outputs in reset",
              {hard_pulse, soft_pulse, query_pulse, prog_pulse, spi_rst_pulse, dac_rst_pulse}, 0);
        check("R1", "held in reset", {cmd_location, partner_mac, soft_debug, soft_mask}, 0);
        rst_n = 1'b1;
        idle(3);
        check("R1", "held after reset", {cmd_location, partner_mac, soft_debug, soft_mask}, 0);

        // R3: minimal hard reset frame (16 bytes)
        frame_base(OWN_MAC, 8'h11, 8'h52); send(K_HARD, "R3", -1, 1); idle(3);
        // R4, R12: padded query
        frame_base(OWN_MAC, 8'h22, 8'h51); pad_to(60); send(K_QUERY, "R4", -1, 1); idle(3);
        // R5: programming frame with mask bytes and data
        frame_base(OWN_MAC, 8'h33, 8'h50);
        fb.push_back(8'h07); fb.push_back(8'hFF); fb.push_back(8'hC0); fb.push_back(8'h00);
        pad_to(70); send(K_PROG, "R5", -1, 1); idle(3);
        // R6, R7: soft reset exactly 24 bytes, SPI flag only
        frame_base(OWN_MAC, 8'h44, 8'hD2);
        fb.push_back(8'h0C); fb.push_back(8'h1D); fb.push_back(8'h2E);
        fb.push_back(8'h3F); fb.push_back(8'h40); fb.push_back(8'h51);
        fb.push_back(8'h5A); fb.push_back(8'h02);
        send(K_SOFT, "R6", -1, 1); idle(3);
        // R11: soft reset with idle gaps inside, DAC flag only, padded
        frame_base(OWN_MAC, 8'h45, 8'hD2);
        for (int i = 0; i < 6; i++) fb.push_back(8'h90 + 8'(i));
        fb.push_back(8'h66); fb.push_back(8'h01); pad_to(40);
        send(K_SOFT, "R11", 18, 1);
        // R12: back-to-back soft (both flags) then hard
        frame_base(OWN_MAC, 8'h46, 8'hD2);
        for (int i = 0; i < 6; i++) fb.push_back(8'hC0 + 8'(i));
        fb.push_back(8'h77); fb.push_back(8'h03);
        send(K_SOFT, "R12", -1, 1);
        frame_base(OWN_MAC, 8'h47, 8'h52); send(K_HARD, "R12", -1, 1); idle(4);

        // R2: last address byte differs, then first byte differs
        frame_base(48'h02_A1_B2_C3_D4_06, 8'h50, 8'h52); pad_to(46);
        send(K_NONE, "R2", -1, 1); hold_check("R2");
        frame_base(48'h03_A1_B2_C3_D4_05, 8'h51, 8'hD2); pad_to(46);
        send(K_NONE, "R2", -1, 1); hold_check("R2");
        // R8: unknown codes
        frame_base(OWN_MAC, 8'h52, 8'h53); pad_to(46); send(K_NONE, "R8", -1, 1); hold_check("R8");
        frame_base(OWN_MAC, 8'h53, 8'hD1); pad_to(46); send(K_NONE, "R8", -1, 1); hold_check("R8");
        // R9: truncated hard (15 bytes) and soft (23 bytes)
        frame_base(OWN_MAC, 8'h54, 8'h52); void'(fb.pop_back());
        send(K_NONE, "R9", -1, 1); hold_check("R9");
        frame_base(OWN_MAC, 8'h55, 8'hD2);
        for (int i = 0; i < 7; i++) fb.push_back(8'h30 + 8'(i));
        send(K_NONE, "R9", -1, 1); hold_check("R9");

        // R11: stray bytes outside a frame, then an accepted hard frame
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = (i == 4); rx_data = 8'hD2;
        end
        frame_base(OWN_MAC, 8'h60, 8'h52); send(K_HARD, "R11", -1, 1); idle(3);
        // R11: soft frame abandoned after partner bytes, restarted as query
        frame_base(OWN_MAC, 8'h61, 8'hD2);
        for (int i = 0; i < 6; i++) fb.push_back(8'hF0 + 8'(i));
        send(K_NONE, "R11", -1, 0);
        frame_base(OWN_MAC, 8'h62, 8'h51); send(K_QUERY, "R11", -1, 1);
        // R7: soft reset with no flags
        frame_base(OWN_MAC, 8'h63, 8'hD2);
        for (int i = 0; i < 6; i++) fb.push_back(8'h10 + 8'(i));
        fb.push_back(8'h88); fb.push_back(8'h00);
        send(K_SOFT, "R7", -1, 1);
        hold_check("R8");

        check("R10", "missing pulses", sb.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule